// File: doc/BRIEF.md
# Two-Source Bit-Rate Tick Generator

This block produces the bit-rate strobe for a serial frame engine. A single 32-bit configuration word holds a divisor, an enable flag and a source select. With the select set, time is measured in pulses of a crystal clock-enable input: the block first divides those pulses by three and then counts the result through the divisor. With the select clear, time is measured in system clock cycles: the block first divides them by four and then counts the result through the divisor.

The output is a one-cycle pulse, synchronous to the system clock, once per bit period. Every write of the configuration word clears both the prescaler and the divisor counter, so the new rate applies from the write onward. Software is expected to rewrite the word only while the transmitter is idle and empty. The divisor field is wide enough to cover rates from 50 baud to 4 Mbaud for typical source frequencies.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset `bit_tick` is low, and it stays low until a configuration word with the enable flag set is written.
- R2: The configuration word is decoded as follows: bits [22:0] hold the divisor D, bit 23 is the enable flag and bit 24 selects the crystal source. Bits [31:25] have no effect on the tick pattern.
- R3: With bit 24 clear and bit 23 set, `bit_tick` pulses once every 4×(D+1) system clock cycles.
- R4: With bits 24 and 23 set, `bit_tick` pulses once every 3×(D+1) cycles in which `xtal_ce` is high. Cycles with `xtal_ce` low do not advance the count.
- R5: While the enable flag (bit 23) of the last written word is clear, `bit_tick` stays low.
- R6: A write restarts the count. `bit_tick` is low in the cycle after the write. The first pulse comes exactly one full period (R3 or R4) of counted units after the write edge, where the write edge itself counts no unit.
- R7: `bit_tick` is high for a single cycle at a time.
- R8: With bit 24 clear, `xtal_ce` has no effect on the tick pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_ce | input | 1 | One-cycle enable marking each crystal clock period |
| baud_wr | input | 1 | Write strobe for the configuration word |
| baud_wdata | input | 32 | Configuration word: divisor [22:0], enable 23, crystal select 24 |
| bit_tick | output | 1 | One-cycle pulse per bit period |

## Verification
The bench builds the block with its default parameters: a 23-bit divisor, prescale ratios of three for the crystal path and four for the core path, and the flag positions 23 and 24. These defaults bring both prescaler lanes, the source select, the ignored upper bits and restarts in the middle of a count within reach. Random divisors are kept to 0–15 and a few directed ones to 40 or less, so that every lane completes many periods, including the smallest period of each path. Divisors near the top of the 23-bit field would take millions of cycles per period. For those the bounded-count properties stand in for a run of a full period.

// File: rtl/baud_pkg.sv
package baud_pkg;
   typedef enum logic {
      SRC_CORE = 1'b0,
      SRC_XTAL = 1'b1
   } baud_src_e;

   localparam int unsigned DEF_REG_W    = 32;
   localparam int unsigned DEF_DIV_W    = 23;
   localparam int unsigned DEF_EN_POS   = 23;
   localparam int unsigned DEF_SEL_POS  = 24;
   localparam int unsigned DEF_XTAL_DIV = 3;
   localparam int unsigned DEF_CORE_DIV = 4;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
   parameter int unsigned RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic adv,
   output logic strobe
);
   if (RATIO < 1) begin : g_bad_ratio
      $error("baud_prescaler: RATIO must be at least 1");
   end

   if (RATIO == 1) begin : g_bypass
      assign strobe = adv && !clear;
   end else begin : g_count
      localparam int unsigned CW = $clog2(RATIO);
      localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
      logic [CW-1:0] cnt;

      assign strobe = adv && !clear && (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (clear) begin
            cnt <= '0;
         end else if (adv) begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
         end
      end

      // R3: the phase count never leaves its range
      p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= LAST);
      // R4: without an advance or a clear the phase is held
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!clear && !adv) |=> $stable(cnt));
      // R6: a clear restarts the phase
      p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         clear |=> (cnt == '0));
   end
endmodule

// File: rtl/baud_divcnt.sv
module baud_divcnt #(
   parameter int unsigned DIV_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [DIV_W-1:0] limit,
   output logic             tick_o
);
   if (DIV_W < 1) begin : g_bad_width
      $error("baud_divcnt: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] dcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt   <= '0;
         tick_o <= 1'b0;
      end else if (clear) begin
         dcnt   <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= 1'b0;
         if (step) begin
            if (dcnt == limit) begin
               dcnt   <= '0;
               tick_o <= 1'b1;
            end else begin
               dcnt <= dcnt + DIV_W'(1);
            end
         end
      end
   end

   // R3: the reload count stays at or below the programmed divisor
   p_dcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dcnt <= limit);
   // R6: a write empties the counter and suppresses the tick
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (dcnt == '0 && !tick_o));
   // R4: with no step the count is held
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !step) |=> ($stable(dcnt) && !tick_o));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int unsigned REG_W    = DEF_REG_W,
   parameter int unsigned DIV_W    = DEF_DIV_W,
   parameter int unsigned EN_POS   = DEF_EN_POS,
   parameter int unsigned SEL_POS  = DEF_SEL_POS,
   parameter int unsigned XTAL_DIV = DEF_XTAL_DIV,
   parameter int unsigned CORE_DIV = DEF_CORE_DIV
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xtal_ce,
   input  logic             baud_wr,
   input  logic [REG_W-1:0] baud_wdata,
   output logic             bit_tick
);
   localparam int unsigned NUM_LANES = 2;

   if (DIV_W > EN_POS || EN_POS >= SEL_POS || SEL_POS >= REG_W) begin : g_bad_layout
      $error("baud_tick_gen: divisor, enable and select fields overlap or exceed the word");
   end
   if (XTAL_DIV < 1 || CORE_DIV < 1) begin : g_bad_ratio
      $error("baud_tick_gen: prescale ratios must be at least 1");
   end

   logic [DIV_W-1:0]     div_q;
   logic                 use_q;
   baud_src_e            src_q;
   logic [NUM_LANES-1:0] lane_strb;
   logic                 unit;
   logic                 unused_bits;

   assign unused_bits = ^baud_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         use_q <= 1'b0;
         src_q <= SRC_CORE;
      end else if (baud_wr) begin
         div_q <= baud_wdata[DIV_W-1:0];
         use_q <= baud_wdata[EN_POS];
         src_q <= baud_wdata[SEL_POS] ? SRC_XTAL : SRC_CORE;
      end
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      logic lane_adv;
      if (i == int'(SRC_XTAL)) begin : g_xtal
         assign lane_adv = use_q && (src_q == SRC_XTAL) && xtal_ce;
      end else begin : g_core
         assign lane_adv = use_q && (src_q == SRC_CORE);
      end

      baud_prescaler #(
         .RATIO((i == int'(SRC_XTAL)) ? XTAL_DIV : CORE_DIV)
      ) u_pre (
         .clk   (clk),
         .rst_n (rst_n),
         .clear (baud_wr),
         .adv   (lane_adv),
         .strobe(lane_strb[i])
      );
   end

   assign unit = |lane_strb;

   baud_divcnt #(
      .DIV_W(DIV_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (baud_wr),
      .step  (unit),
      .limit (div_q),
      .tick_o(bit_tick)
   );

   // R8: at most one prescaler lane fires in a cycle
   p_one_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_strb));
   // R5: a disabled divisor yields no tick
   p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !use_q |-> !bit_tick);
   // R6: the cycle after a write carries no tick
   p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      baud_wr |=> !bit_tick);

   if (XTAL_DIV > 1 && CORE_DIV > 1) begin : g_pulse_chk
      // R7: the tick never lasts two cycles
      p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
         bit_tick |=> !bit_tick);
   end
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
   localparam int unsigned XTAL_PRE = 3;
   localparam int unsigned CORE_PRE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xtal_ce = 1'b0;
   logic        baud_wr = 1'b0;
   logic [31:0] baud_wdata = '0;
   logic        bit_tick;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [22:0] m_div = '0;
   logic        m_use = 1'b0;
   logic        m_sel = 1'b0;
   longint      units = 0;

   always #5 clk = ~clk;

   baud_tick_gen u_baud_tick_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .xtal_ce   (xtal_ce),
      .baud_wr   (baud_wr),
      .baud_wdata(baud_wdata),
      .bit_tick  (bit_tick)
   );

   function automatic longint period_units(input logic sel, input logic [22:0] d);
      return longint'(sel ? XTAL_PRE : CORE_PRE) * (longint'(d) + 1);
   endfunction

   function automatic logic [31:0] mk_word(input logic [6:0] hi, input logic sel,
                                           input logic en, input logic [22:0] d);
      return {hi, sel, en, d};
   endfunction

   task automatic cyc(input logic w, input logic [31:0] d, input logic x, input string tag);
      logic exp_t;
      logic counted;
      baud_wr    = w;
      baud_wdata = d;
      xtal_ce    = x;
      @(negedge clk);
      if (w) begin
         m_div = d[22:0];
         m_use = d[23];
         m_sel = d[24];
         units = 0;
         exp_t = 1'b0;
      end else if (!m_use) begin
         exp_t = 1'b0;
      end else begin
         counted = m_sel ? x : 1'b1;
         if (counted) units++;
         exp_t = counted && ((units % period_units(m_sel, m_div)) == 0);
      end
      checks++;
      if (bit_tick !== exp_t) begin
         fails++;
         $display("FAIL %s: bit_tick=%b expected %b (units=%0d div=%0d sel=%b en=%b)",
                  tag, bit_tick, exp_t, units, m_div, m_sel, m_use);
      end
   endtask

   task automatic run(input int n, input bit rand_x, input string tag);
      for (int k = 0; k < n; k++) begin
         cyc(1'b0, baud_wdata, rand_x ? 1'($urandom_range(1, 0)) : 1'b1, tag);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not end, got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      checks++;
      if (bit_tick !== 1'b0) begin
         fails++;
         $display("FAIL R1: bit_tick=%b during reset expected 0", bit_tick);
      end
      rst_n = 1'b1;
      // R1: nothing before an enabled write
      run(30, 1'b1, "R1");

      // R5: enable flag clear, on both sources
      cyc(1'b1, mk_word(7'h00, 1'b0, 1'b0, 23'd1), 1'b1, "R5");
      run(60, 1'b1, "R5");
      cyc(1'b1, mk_word(7'h00, 1'b1, 1'b0, 23'd0), 1'b1, "R5");
      run(60, 1'b1, "R5");

      // R3: core path, smallest and larger divisors
      cyc(1'b1, mk_word(7'h00, 1'b0, 1'b1, 23'd0), 1'b1, "R3");
      run(40, 1'b0, "R3");
      cyc(1'b1, mk_word(7'h00, 1'b0, 1'b1, 23'd5), 1'b1, "R3");
      run(200, 1'b0, "R3");
      cyc(1'b1, mk_word(7'h00, 1'b0, 1'b1, 23'd40), 1'b1, "R3");
      run(400, 1'b0, "R3");

      // R8: core path with a toggling crystal enable
      cyc(1'b1, mk_word(7'h00, 1'b0, 1'b1, 23'd2), 1'b0, "R8");
      run(200, 1'b1, "R8");

      // R4: crystal path, steady and irregular enables
      cyc(1'b1, mk_word(7'h00, 1'b1, 1'b1, 23'd0), 1'b1, "R4");
      run(60, 1'b0, "R4");
      cyc(1'b1, mk_word(7'h00, 1'b1, 1'b1, 23'd3), 1'b0, "R4");
      run(300, 1'b1, "R4");

      // R2: upper bits set must not change the pattern
      cyc(1'b1, mk_word(7'h7F, 1'b0, 1'b1, 23'd1), 1'b1, "R2");
      run(100, 1'b1, "R2");
      cyc(1'b1, mk_word(7'h55, 1'b1, 1'b1, 23'd2), 1'b1, "R2");
      run(150, 1'b1, "R2");

      // R7: back-to-back smallest periods, checked per cycle
      cyc(1'b1, mk_word(7'h00, 1'b1, 1'b1, 23'd0), 1'b1, "R7");
      run(30, 1'b0, "R7");

      // R6: random rewrites in the middle of counts
      for (int it = 0; it < 80; it++) begin
         logic [31:0] w;
         w = mk_word(7'($urandom()), 1'($urandom_range(1, 0)),
                     ($urandom_range(7, 0) != 0), 23'($urandom_range(15, 0)));
         cyc(1'b1, w, 1'($urandom_range(1, 0)), "R6");
         run(int'($urandom_range(150, 1)), 1'b1, "R6");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule